// File: doc/BRIEF.md
# VLAN Resolution Table

This block stores the VLAN domain table of a small multi-port switch. Each slot holds a 12-bit VLAN identifier and two 5-bit port masks. The membership mask lists the ports that belong to the VLAN. The tag mask lists the ports on which frames leave with their tag kept. A slot whose membership mask is zero counts as unused. Software reaches every slot through one 32-bit word, using a plain read and write strobe. Both masks share the low five bits of that word. Qualifier bits in a write select which mask is updated. A per-slot select flag chooses which mask a read shows, and software flips that flag with a dedicated write bit.

The forwarding path uses a separate lookup port. A VLAN identifier is presented with a valid strobe, and one cycle later the block reports whether an in-use slot carries that identifier. On a hit it also reports the slot number and both masks. Search, allocation and mask editing are left to software, which performs them with ordinary reads and writes. Neither port applies back-pressure. A read or lookup is accepted in every cycle in which its strobe is high, and its result is presented for exactly one cycle. The consumer must take it in that cycle.

Top module: `vlan_res_table`

## Requirements
- R1: After reset every slot holds identifier 0, both masks zero and select flag 0, so reading any slot returns 0.
- R2: A write with bit 28 clear always loads bits 16:5 into the slot's identifier. It loads bits 4:0 into the membership mask only when bit 30 is set, and into the tag mask only when bit 29 is set.
- R3: A write with bit 28 set flips that slot's select flag and changes nothing else in the slot, whatever the other written bits are.
- R4: A read returns its word with rdata_valid high in the next cycle, and with rdata_valid low after any cycle without a read. The word has the select flag in bit 28 and the identifier in bits 16:5. Bits 4:0 hold the tag mask when the flag is 1 and the membership mask when it is 0. All other bits are zero.
- R5: The select flag is held separately for each slot. Flipping one slot's flag leaves every other slot's flag unchanged.
- R6: A lookup returns res_valid one cycle after lk_valid. It reports a hit when some slot with a nonzero membership mask has an identifier equal to lk_vid. On a hit it reports the lowest such slot number and that slot's two masks.
- R7: A slot whose membership mask is zero never produces a hit, even when its identifier matches.
- R8: On a miss, res_idx, res_member and res_tag are all zero.
- R9: A read or lookup issued in the same cycle as a write sees the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the slot selected by addr |
| rd_en | input | 1 | Read strobe for the slot selected by addr |
| addr | input | 5 | Slot number for reads and writes |
| wdata | input | 32 | Write word |
| rdata | output | 32 | Read word, valid with rdata_valid |
| rdata_valid | output | 1 | High for one cycle, the cycle after a read |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vid | input | 12 | Identifier to look up |
| res_valid | output | 1 | High for one cycle, the cycle after a lookup |
| res_hit | output | 1 | Lookup found an in-use slot |
| res_idx | output | 5 | Lowest matching slot number, zero on a miss |
| res_member | output | 5 | Membership mask of the matching slot |
| res_tag | output | 5 | Tag mask of the matching slot |

## Verification
The hardest state to reach is a table in which several in-use slots share one identifier while free slots also carry that identifier. Only that state exercises the lowest-index priority and the rule that free slots are excluded. The random stimulus draws identifiers from a pool of six values and writes membership masks that are often zero, so duplicates and matching free slots appear throughout the run. Some stimulus cycles combine a write, a read and a lookup, with junk in the ignored bits of the write word. Directed sequences add the flip, read and flip-back pattern that software uses to edit a tag mask.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned PM_WE_BIT  = 30;
  localparam int unsigned TM_WE_BIT  = 29;
  localparam int unsigned FLIP_BIT   = 28;
  localparam int unsigned MASK_LSB   = 0;
endpackage

// File: rtl/vtab_entry.sv
module vtab_entry #(
  parameter int unsigned VID_W = 12,
  parameter int unsigned PORTS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             wr_flip,
  input  logic             wr_pm,
  input  logic             wr_tm,
  input  logic [VID_W-1:0] wr_vid,
  input  logic [PORTS-1:0] wr_mask,
  output logic [VID_W-1:0] vid,
  output logic [PORTS-1:0] member,
  output logic [PORTS-1:0] tag,
  output logic             sel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid    <= '0;
      member <= '0;
      tag    <= '0;
      sel    <= 1'b0;
    end else if (wr) begin
      if (wr_flip) begin
        sel <= ~sel;
      end else begin
        vid <= wr_vid;
        if (wr_pm) member <= wr_mask;
        if (wr_tm) tag    <= wr_mask;
      end
    end
  end

  // R3: a flip write changes only the select flag
  a_r3_flip_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr && wr_flip |=> (sel != $past(sel)) && $stable(vid) && $stable(member) && $stable(tag));

  // R2: masks move only under their own enable
  a_r2_pm_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && !wr_flip && wr_pm) |=> $stable(member));
  a_r2_tm_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && !wr_flip && wr_tm) |=> $stable(tag));

  // R5: select flag untouched when this slot is not written
  a_r5_sel_private: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(sel));
endmodule

// File: rtl/vtab_match.sv
module vtab_match #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VID_W   = 12,
  parameter int unsigned PORTS   = 5,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][VID_W-1:0] vid_all,
  input  logic [ENTRIES-1:0][PORTS-1:0] mem_all,
  input  logic [ENTRIES-1:0][PORTS-1:0] tag_all,
  input  logic [VID_W-1:0]              key,
  output logic                          hit,
  output logic [AW-1:0]                 idx,
  output logic [PORTS-1:0]              member,
  output logic [PORTS-1:0]              tag
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = (|mem_all[g]) && (vid_all[g] == key);
  end

  always_comb begin
    hit    = |eq;
    idx    = '0;
    member = '0;
    tag    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) begin
        idx    = i[AW-1:0];
        member = mem_all[i];
        tag    = tag_all[i];
      end
    end
  end
endmodule

// File: rtl/vtab_rdmux.sv
module vtab_rdmux #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VID_W   = 12,
  parameter int unsigned PORTS   = 5,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][VID_W-1:0] vid_all,
  input  logic [ENTRIES-1:0][PORTS-1:0] mem_all,
  input  logic [ENTRIES-1:0][PORTS-1:0] tag_all,
  input  logic [ENTRIES-1:0]            sel_all,
  input  logic [AW-1:0]                 addr,
  output logic [vtab_pkg::REG_W-1:0]    word
);
  import vtab_pkg::*;

  always_comb begin
    word = '0;
    word[FLIP_BIT] = sel_all[addr];
    word[PORTS +: VID_W] = vid_all[addr];
    word[MASK_LSB +: PORTS] = sel_all[addr] ? tag_all[addr] : mem_all[addr];
  end
endmodule

// File: rtl/vlan_res_table.sv
module vlan_res_table #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VID_W   = 12,
  parameter int unsigned PORTS   = 5,
  localparam int unsigned AW     = $clog2(ENTRIES),
  localparam int unsigned VMSB   = PORTS + VID_W - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [AW-1:0]              addr,
  input  logic [vtab_pkg::REG_W-1:0] wdata,
  output logic [vtab_pkg::REG_W-1:0] rdata,
  output logic                       rdata_valid,
  input  logic                       lk_valid,
  input  logic [VID_W-1:0]           lk_vid,
  output logic                       res_valid,
  output logic                       res_hit,
  output logic [AW-1:0]              res_idx,
  output logic [PORTS-1:0]           res_member,
  output logic [PORTS-1:0]           res_tag
);
  import vtab_pkg::*;

  logic [ENTRIES-1:0][VID_W-1:0] vid_all;
  logic [ENTRIES-1:0][PORTS-1:0] mem_all;
  logic [ENTRIES-1:0][PORTS-1:0] tag_all;
  logic [ENTRIES-1:0]            sel_all;

  logic unused_wbits;
  assign unused_wbits = ^{wdata[REG_W-1], wdata[FLIP_BIT-1:VMSB+1]};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    vtab_entry #(.VID_W(VID_W), .PORTS(PORTS)) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_en && (addr == AW'(g))),
      .wr_flip (wdata[FLIP_BIT]),
      .wr_pm   (wdata[PM_WE_BIT]),
      .wr_tm   (wdata[TM_WE_BIT]),
      .wr_vid  (wdata[PORTS +: VID_W]),
      .wr_mask (wdata[MASK_LSB +: PORTS]),
      .vid     (vid_all[g]),
      .member  (mem_all[g]),
      .tag     (tag_all[g]),
      .sel     (sel_all[g])
    );
  end

  logic [REG_W-1:0] rd_word;
  vtab_rdmux #(.ENTRIES(ENTRIES), .VID_W(VID_W), .PORTS(PORTS)) u_rdmux (
    .vid_all (vid_all),
    .mem_all (mem_all),
    .tag_all (tag_all),
    .sel_all (sel_all),
    .addr    (addr),
    .word    (rd_word)
  );

  logic             m_hit;
  logic [AW-1:0]    m_idx;
  logic [PORTS-1:0] m_mem;
  logic [PORTS-1:0] m_tag;
  vtab_match #(.ENTRIES(ENTRIES), .VID_W(VID_W), .PORTS(PORTS)) u_match (
    .vid_all (vid_all),
    .mem_all (mem_all),
    .tag_all (tag_all),
    .key     (lk_vid),
    .hit     (m_hit),
    .idx     (m_idx),
    .member  (m_mem),
    .tag     (m_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata       <= '0;
      rdata_valid <= 1'b0;
      res_valid   <= 1'b0;
      res_hit     <= 1'b0;
      res_idx     <= '0;
      res_member  <= '0;
      res_tag     <= '0;
    end else begin
      rdata_valid <= rd_en;
      if (rd_en) rdata <= rd_word;
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_hit    <= m_hit;
        res_idx    <= m_idx;
        res_member <= m_mem;
        res_tag    <= m_tag;
      end
    end
  end

  // R4: read data one cycle after the strobe, reserved bits zero
  a_r4_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rdata_valid);
  a_r4_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rdata_valid);
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> (rdata[REG_W-1:FLIP_BIT+1] == '0) && (rdata[FLIP_BIT-1:VMSB+1] == '0));
  // R6: lookup result one cycle after the request
  a_r6_lk_latency: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  // R7: a hit always names an in-use slot
  a_r7_hit_in_use: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit |-> res_member != '0);
  // R8: misses report zeros
  a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> (res_idx == '0) && (res_member == '0) && (res_tag == '0));
endmodule

// File: tb/vlan_res_table_test.sv
module vlan_res_table_test;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, lk_valid = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [11:0] lk_vid = '0;
  logic [31:0] rdata;
  logic        rdata_valid, res_valid, res_hit;
  logic [4:0]  res_idx, res_member, res_tag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] m_vid [N];
  logic [4:0]  m_mem [N];
  logic [4:0]  m_tag [N];
  logic        m_sel [N];

  always #5 clk = ~clk;

  vlan_res_table uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_valid(rdata_valid),
    .lk_valid(lk_valid), .lk_vid(lk_vid), .res_valid(res_valid),
    .res_hit(res_hit), .res_idx(res_idx), .res_member(res_member), .res_tag(res_tag)
  );

  function automatic logic [31:0] exp_word(input int a);
    logic [31:0] w = '0;
    w[28]   = m_sel[a];
    w[16:5] = m_vid[a];
    w[4:0]  = m_sel[a] ? m_tag[a] : m_mem[a];
    return w;
  endfunction

  function automatic logic [31:0] exp_lookup(input logic [11:0] v);
    for (int i = 0; i < N; i++)
      if (m_mem[i] != 0 && m_vid[i] == v)
        return {16'd0, 1'b1, 5'(i), m_mem[i], m_tag[i]};
    return 32'd0;
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    if (d[28]) m_sel[a] = ~m_sel[a];
    else begin
      m_vid[a] = d[16:5];
      if (d[30]) m_mem[a] = d[4:0];
      if (d[29]) m_tag[a] = d[4:0];
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check results at the following negedge.
  task automatic step(input bit we, input bit re, input int a, input logic [31:0] d,
                      input bit lv, input logic [11:0] v, input string tag);
    logic [31:0] er, el;
    wr_en = we; rd_en = re; addr = 5'(a); wdata = d; lk_valid = lv; lk_vid = v;
    er = exp_word(a);
    el = exp_lookup(v);
    @(posedge clk);
    if (we) model_write(a, d);
    @(negedge clk);
    chk({tag, " rdata_valid"}, {31'd0, rdata_valid}, {31'd0, re});
    if (re) chk({tag, " rdata"}, rdata, er);
    chk({tag, " res_valid"}, {31'd0, res_valid}, {31'd0, lv});
    if (lv) chk({tag, " lookup"}, {16'd0, res_hit, res_idx, res_member, res_tag}, el);
    wr_en = 1'b0; rd_en = 1'b0; lk_valid = 1'b0;
  endtask

  function automatic logic [31:0] mk(input bit flip, input bit pm, input bit tm,
                                     input logic [11:0] v, input logic [4:0] m);
    return {1'b0, pm, tm, flip, 11'd0, v, m};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vid[i] = '0; m_mem[i] = '0; m_tag[i] = '0; m_sel[i] = 1'b0;
    end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents, and R7: default VID 0 on free slots never hits
    for (int i = 0; i < N; i++) step(0, 1, i, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 1, 12'd0, "R7 reset lookup");

    // R2: identifier always loaded, masks gated
    step(1, 0, 3, mk(0, 1, 0, 12'd100, 5'b00101), 0, 0, "R2");
    step(0, 1, 3, 0, 0, 0, "R2 member write");
    step(1, 0, 3, mk(0, 0, 1, 12'd100, 5'b00001), 0, 0, "R2");
    step(0, 1, 3, 0, 0, 0, "R2 tag only");
    // R3/R4: flip shows tag mask, junk bits ignored
    step(1, 0, 3, 32'hF7FF_FFFF & ~32'h0800_0000 | 32'h1000_0000 | 32'h8FFF_FFFF, 0, 0, "R3");
    step(0, 1, 3, 0, 0, 0, "R3 flip view");
    // R5: neighbour flag unchanged
    step(0, 1, 4, 0, 0, 0, "R5 neighbour");
    // tag edit sequence: flip, read, flip back, write
    step(1, 0, 3, mk(1, 0, 0, 0, 0), 0, 0, "R3");
    step(0, 1, 3, 0, 0, 0, "R4 back to member");
    // R6: duplicates, lowest index wins
    step(1, 0, 7, mk(0, 1, 1, 12'd100, 5'b10000), 0, 0, "R6");
    step(0, 0, 0, 0, 1, 12'd100, "R6 priority");
    // R7: freeing slot 3 moves the hit to slot 7
    step(1, 0, 3, mk(0, 1, 0, 12'd100, 5'b00000), 0, 0, "R7");
    step(0, 0, 0, 0, 1, 12'd100, "R7 free slot");
    // R8: miss
    step(0, 0, 0, 0, 1, 12'd999, "R8 miss");
    // R9: same-cycle write, read and lookup see old contents
    step(1, 1, 7, mk(0, 1, 0, 12'd555, 5'b00011), 1, 12'd555, "R9");
    step(0, 1, 7, 0, 1, 12'd555, "R9 after");

    // Random phase: small VID pool drives duplicates and free matches.
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] d;
      d = $urandom;
      d[16:5] = 12'($urandom_range(0, 5));
      d[28] = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 3) == 0) d[4:0] = 5'd0;
      step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom_range(0, N - 1), d,
           $urandom_range(0, 1) == 1, 12'($urandom_range(0, 6)), "R4 R6 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule